// File: doc/BRIEF.md
# Tick-Driven Nanosecond Timestamp Counter

This block keeps a wide nanosecond timestamp in a fast bus clock domain. The count is paced by a slower, accurate reference clock, but that clock never drives the counter register. In the reference domain a single flip-flop inverts on every rising reference edge. Its level crosses into the bus domain through a chain of synchronizer flip-flops. A change detector compares the synchronized level with its value one bus cycle earlier and emits a one-cycle enable. On that enable the counter adds a fixed step, which is the reference period in nanoseconds.

With the default step of 100 and a 10 MHz reference, the counter reads elapsed nanoseconds at a resolution of one reference period. Every bus-side flop shares the bus clock, so the counter can be read directly by bus logic. A different reference frequency only needs a different step parameter.

Top module: `tick_ns_counter`

## Requirements
- R1: While `rst_n` is low, and on the first bus cycle after it rises, `count_ns` is zero.
- R2: Each rising edge of `ref_clk` increases `count_ns` by exactly `STEP_NS`, once. The change becomes visible within `SYNC_STAGES`+2 bus clock cycles of the edge.
- R3: While `ref_clk` has no rising edges, `count_ns` holds its value on every bus cycle.
- R4: `count_ns` is an unsigned `COUNT_W`-bit value and wraps modulo 2^`COUNT_W` when a step carries past its top bit.
- R5: Asserting `rst_n` low in the middle of operation clears both domains, and the reference-side toggle restarts at 0. Releasing reset while `ref_clk` is idle therefore produces no count change, and the next reference edge counts as the first step.
- R6: The `ref_clk` period must be at least three bus clock periods. Under that condition, each internal tick enable is high for exactly one bus cycle per reference edge.
- R7: Elaboration rejects any of these settings: `SYNC_STAGES` below 2, `STEP_NS` of 0, or a `STEP_NS` that does not fit in `COUNT_W` bits. Any legal combination, including narrow counters and deeper synchronizers, behaves as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Slow, accurate reference clock that paces the count |
| bus_clk | input | 1 | Fast clock that owns the counter |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| count_ns | output | COUNT_W | Elapsed time in nanoseconds, bus clock domain |

## Verification
The hardest case is a reference edge that lands close to a bus clock edge, at the minimum allowed ratio of three bus periods per reference period. A tick that lasted two cycles, or a toggle change that was missed, would only appear as a wrong sum. The stimulus therefore drives reference edges on their own nanosecond delays, unrelated to the 8 ns bus period. It uses half-periods as short as 12 ns and checks the total after every burst. A second, 10-bit instance with a deeper synchronizer receives the same edges and is pushed through several wraps.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int unsigned TSC_STEP_NS_DEF = 100;
   localparam int unsigned TSC_COUNT_W_DEF = 64;
   localparam int unsigned TSC_SYNC_DEF    = 2;
   localparam int unsigned TSC_SYNC_MIN    = 2;
endpackage

// File: rtl/tsc_ref_toggle.sv
module tsc_ref_toggle (
   input  logic ref_clk,
   input  logic rst_n,
   output logic toggle_o
);
   logic toggle_q;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) toggle_q <= 1'b0;
      else        toggle_q <= ~toggle_q;
   end

   assign toggle_o = toggle_q;

   AST_TOGGLE_FLIP: assert property (@(posedge ref_clk) disable iff (!rst_n)
      1'b1 |=> (toggle_q != $past(toggle_q))); // R2
endmodule

// File: rtl/tsc_sync.sv
module tsc_sync #(
   parameter int unsigned STAGES = tsc_pkg::TSC_SYNC_DEF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < tsc_pkg::TSC_SYNC_MIN) begin : g_bad_stages
         $error("tsc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= d_i;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/tsc_tick_detect.sv
module tsc_tick_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic tick_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_i;
   end

   assign tick_o = level_i ^ prev_q;

   AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R6
endmodule

// File: rtl/tsc_ns_accum.sv
module tsc_ns_accum #(
   parameter int unsigned COUNT_W = tsc_pkg::TSC_COUNT_W_DEF,
   parameter int unsigned STEP    = tsc_pkg::TSC_STEP_NS_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   output logic [COUNT_W-1:0] count_o
);
   localparam logic [COUNT_W-1:0] STEP_V = COUNT_W'(STEP);

   generate
      if (STEP == 0) begin : g_bad_step
         $error("tsc_ns_accum: STEP must be nonzero");
      end
      if ((64'(STEP) >> COUNT_W) != 64'd0) begin : g_step_wide
         $error("tsc_ns_accum: STEP does not fit in COUNT_W bits");
      end
   endgenerate

   logic [COUNT_W-1:0] count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_q <= '0;
      else if (tick_i) count_q <= count_q + STEP_V;
   end

   assign count_o = count_q;

   AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |=> (count_q == $past(count_q) + STEP_V)); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(count_q)); // R3
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (count_q == '0)); // R1
endmodule

// File: rtl/tick_ns_counter.sv
module tick_ns_counter #(
   parameter int unsigned COUNT_W     = tsc_pkg::TSC_COUNT_W_DEF,
   parameter int unsigned STEP_NS     = tsc_pkg::TSC_STEP_NS_DEF,
   parameter int unsigned SYNC_STAGES = tsc_pkg::TSC_SYNC_DEF
) (
   input  logic               ref_clk,
   input  logic               bus_clk,
   input  logic               rst_n,
   output logic [COUNT_W-1:0] count_ns
);
   logic ref_toggle;
   logic bus_level;
   logic bus_tick;

   tsc_ref_toggle u_toggle (
      .ref_clk  (ref_clk),
      .rst_n    (rst_n),
      .toggle_o (ref_toggle)
   );

   tsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (bus_clk),
      .rst_n (rst_n),
      .d_i   (ref_toggle),
      .q_o   (bus_level)
   );

   tsc_tick_detect u_detect (
      .clk     (bus_clk),
      .rst_n   (rst_n),
      .level_i (bus_level),
      .tick_o  (bus_tick)
   );

   tsc_ns_accum #(.COUNT_W(COUNT_W), .STEP(STEP_NS)) u_accum (
      .clk     (bus_clk),
      .rst_n   (rst_n),
      .tick_i  (bus_tick),
      .count_o (count_ns)
   );

   AST_FIRST_CLEAR: assert property (@(posedge bus_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (count_ns == '0)); // R5
endmodule

// File: tb/tick_ns_counter_tb.sv
module tick_ns_counter_tb;
   localparam int NVEC = 8;
   localparam int VEC_EDGES [NVEC] = '{1, 2, 4, 3, 7, 5, 1, 6};
   localparam int VEC_HALF  [NVEC] = '{20, 12, 17, 33, 12, 25, 61, 14};

   logic        bus_clk = 1'b0;
   logic        ref_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic [63:0] count_ns;
   logic [9:0]  count_small;

   int n_chk  = 0;
   int n_fail = 0;
   longint total = 0;

   always #4 bus_clk = ~bus_clk;

   tick_ns_counter u_dut (
      .ref_clk  (ref_clk),
      .bus_clk  (bus_clk),
      .rst_n    (rst_n),
      .count_ns (count_ns)
   );

   // R7: narrow counter with a deeper synchronizer
   tick_ns_counter #(.COUNT_W(10), .STEP_NS(100), .SYNC_STAGES(3)) u_small (
      .ref_clk  (ref_clk),
      .bus_clk  (bus_clk),
      .rst_n    (rst_n),
      .count_ns (count_small)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic ref_edges(input int n, input int half);
      for (int k = 0; k < n; k++) begin
         #(half) ref_clk = 1'b1;
         #(half) ref_clk = 1'b0;
      end
   endtask

   task automatic settle(input int cyc);
      repeat (cyc) @(negedge bus_clk);
   endtask

   task automatic check_both(input string tag);
      chk({tag, " big"}, longint'(count_ns), total * 100);
      chk({tag, " small R4 R7"}, longint'(count_small), (total * 100) % 1024);
   endtask

   initial begin
      #800000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      longint held;
      settle(5);
      check_both("R1 in reset");
      rst_n = 1'b1;
      settle(1);
      check_both("R1 after release");

      // Table walk: bursts of reference edges, R2 and R6
      for (int v = 0; v < NVEC; v++) begin
         ref_edges(VEC_EDGES[v], VEC_HALF[v]);
         total += VEC_EDGES[v];
         settle(8);
         check_both("R2 R6 vector");
      end

      // R3: idle reference holds the count
      held = longint'(count_ns);
      settle(200);
      chk("R3 idle hold", longint'(count_ns), held);

      // R5: reset in mid-run
      ref_edges(3, 15);
      settle(2);
      rst_n = 1'b0;
      total = 0;
      settle(3);
      check_both("R5 during reset");
      rst_n = 1'b1;
      settle(50);
      check_both("R5 no spurious tick");
      ref_edges(1, 19);
      total = 1;
      settle(8);
      check_both("R5 first edge after reset");
      ref_edges(10, 12);
      total += 10;
      settle(8);
      check_both("R2 R4 wrap burst");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule